// File: doc/BRIEF.md
# Bytecode Fetch-Decode Dispatch Unit

This unit sits beside a small microcontroller core and takes the fetch and decode steps of a bytecode interpreter off the software. It keeps the interpreter's own program counter, the virtual program counter (VPC), and a handler table base. When the core executes the dispatch instruction at the end of a handler, the unit stalls the core. It reads the next bytecode from program memory at VPC and advances VPC by one. It then reads a little-endian handler pointer from the table entry that the bytecode selects. Finally it pulses a redirect that loads the core's program counter with that pointer. The handler that runs next does the execute phase and finishes with its own dispatch, so handlers chain straight into one another with no central software loop.

Two more instructions move values from the accumulator: one into VPC and one into the table base. The current VPC is always on an output, so the core can copy it back into the accumulator. Program memory answers one cycle after each read request. The unit waits for every byte before it takes the next step.

Top module: `bc_dispatch`

## Requirements
- R1: After reset, VPC and the table base are 0, the sequencer is idle, and `busy_o`, `pm_req_o` and `pc_load_o` are low.
- R2: In the cycle `dispatch_i` is accepted, `pm_req_o` is high and `pm_addr_o` equals VPC, which is the fetch of the bytecode.
- R3: In the cycle after the fetch, the bytecode is on `pm_data_i`. In that cycle the unit requests the table entry byte at base + bytecode*2. In the following cycle it requests base + bytecode*2 + 1. All address sums wrap modulo 2^16.
- R4: On the fourth cycle after the dispatch cycle, `pc_load_o` is high for exactly one cycle. In that cycle `pc_target_o` = (byte at entry+1)*256 + (byte at entry), which is little-endian.
- R5: Each dispatch increases VPC by one, and 16'hFFFF advances to 16'h0000.
- R6: `busy_o` is high from the dispatch cycle through the `pc_load_o` cycle, five cycles in all. It is low in the cycle after that.
- R7: `vpc_o` always shows VPC. An accepted `vpc_load_i` makes VPC equal to `acc_i` from the next cycle on.
- R8: An accepted `base_load_i` makes the table base equal to `acc_i`, and later dispatches index from that base.
- R9: When `vpc_load_i` and `dispatch_i` arrive in the same cycle, the bytecode is fetched from `acc_i`. VPC then ends at `acc_i` + 1.
- R10: When `base_load_i` and `dispatch_i` arrive in the same cycle, that same dispatch reads its entry from the new base.
- R11: While the unit is busy after the dispatch cycle, `dispatch_i`, `vpc_load_i` and `base_load_i` are ignored. No extra redirect occurs, and VPC and the base keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dispatch_i | input | 1 | Dispatch instruction executed by the core |
| vpc_load_i | input | 1 | Load VPC from the accumulator |
| base_load_i | input | 1 | Load the handler table base from the accumulator |
| acc_i | input | 16 | Accumulator value from the core |
| vpc_o | output | 16 | Current VPC, for copying into the accumulator |
| pm_req_o | output | 1 | Program memory read request |
| pm_addr_o | output | 16 | Program memory read address |
| pm_data_i | input | 8 | Program memory read data, valid one cycle after the request |
| busy_o | output | 1 | Stall request to the core pipeline |
| pc_load_o | output | 1 | One-cycle strobe that loads the core program counter |
| pc_target_o | output | 16 | Handler address for the core program counter |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an accumulator load of VPC or of the base together with the dispatch that consumes it. The bench raises both strobes on one edge. It then checks that the fetch address, the final VPC and the entry addresses reflect the new accumulator value. The second pair is a dispatch in flight together with fresh commands. During the entry reads the bench raises all three strobes again with an unrelated value. It then checks that no second redirect appears, that VPC ends one above its earlier value, and that the next dispatch still indexes from the old base.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPCODE = 2'd1,
        ST_ENTRY  = 2'd2,
        ST_JUMP   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/bcd_regs.sv
module bcd_regs #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vpc_we,
    input  logic              base_we,
    input  logic              vpc_inc,
    input  logic [ADDR_W-1:0] acc,
    output logic [ADDR_W-1:0] vpc_q_o,
    output logic [ADDR_W-1:0] base_q_o,
    output logic [ADDR_W-1:0] fetch_addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] vpc;
        logic [ADDR_W-1:0] base;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (vpc_we)       r_d.vpc = acc;
        else if (vpc_inc) r_d.vpc = r_q.vpc + 1'b1;
        if (base_we)      r_d.base = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign vpc_q_o      = r_q.vpc;
    assign base_q_o     = r_q.base;
    assign fetch_addr_o = vpc_we ? acc : r_q.vpc;

    // R11
    wr_inc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vpc_we && vpc_inc));

    // R5
    vpc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vpc_inc |=> (vpc_q_o == $past(vpc_q_o) + 1'b1));
endmodule

// File: rtl/bcd_addr_gen.sv
module bcd_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int BC_W   = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BC_W-1:0]   opcode,
    output logic [ADDR_W-1:0] entry
);
    localparam int ENTRY_BYTES = ADDR_W / 8;

    generate
        if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0) begin : g_shift
            localparam int SH = $clog2(ENTRY_BYTES);
            assign entry = base + (ADDR_W'(opcode) << SH);
        end else begin : g_mult
            assign entry = base + ADDR_W'(ADDR_W'(opcode) * ENTRY_BYTES);
        end
    endgenerate
endmodule

// File: rtl/bcd_seq.sv
module bcd_seq
    import bcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BC_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] entry_start,
    input  logic [BC_W-1:0]   pm_data,
    output logic              idle_o,
    output logic              pm_req_o,
    output logic [ADDR_W-1:0] pm_addr_o,
    output logic              vpc_inc_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_target_o
);
    localparam int ENTRY_BYTES = ADDR_W / 8;
    localparam int IDX_W       = (ENTRY_BYTES > 1) ? $clog2(ENTRY_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_BYTES - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] entry;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] target;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        pm_req_o  = 1'b0;
        pm_addr_o = '0;
        vpc_inc_o = 1'b0;
        pc_load_o = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (go) begin
                    pm_req_o   = 1'b1;
                    pm_addr_o  = fetch_addr;
                    s_d.idx    = '0;
                    s_d.target = '0;
                    s_d.st     = ST_OPCODE;
                end
            end
            ST_OPCODE: begin
                s_d.entry = entry_start;
                pm_req_o  = 1'b1;
                pm_addr_o = entry_start;
                vpc_inc_o = 1'b1;
                s_d.st    = ST_ENTRY;
            end
            ST_ENTRY: begin
                s_d.target = s_q.target | (ADDR_W'(pm_data) << (8 * s_q.idx));
                if (s_q.idx == LAST_IDX) begin
                    s_d.st = ST_JUMP;
                end else begin
                    pm_req_o  = 1'b1;
                    pm_addr_o = s_q.entry + ADDR_W'(s_q.idx) + 1'b1;
                    s_d.idx   = s_q.idx + 1'b1;
                end
            end
            ST_JUMP: begin
                pc_load_o = 1'b1;
                s_d.st    = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, entry: '0, idx: '0, target: '0};
        else        s_q <= s_d;
    end

    assign idle_o      = (s_q.st == ST_IDLE);
    assign pc_target_o = s_q.target;

    // R4
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o);

    // R3
    entry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ENTRY && pm_req_o) |-> (pm_addr_o == $past(pm_addr_o) + 1'b1));

    // R5
    one_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vpc_inc_o |=> !vpc_inc_o);
endmodule

// File: rtl/bc_dispatch.sv
module bc_dispatch #(
    parameter int ADDR_W = 16,
    parameter int BC_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dispatch_i,
    input  logic              vpc_load_i,
    input  logic              base_load_i,
    input  logic [ADDR_W-1:0] acc_i,
    output logic [ADDR_W-1:0] vpc_o,
    output logic              pm_req_o,
    output logic [ADDR_W-1:0] pm_addr_o,
    input  logic [BC_W-1:0]   pm_data_i,
    output logic              busy_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_target_o
);
    logic              seq_idle, go, vpc_we, base_we, vpc_inc;
    logic [ADDR_W-1:0] base_q, fetch_addr, entry_start;

    assign go      = dispatch_i  & seq_idle;
    assign vpc_we  = vpc_load_i  & seq_idle;
    assign base_we = base_load_i & seq_idle;
    assign busy_o  = go | ~seq_idle;

    bcd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .vpc_we(vpc_we), .base_we(base_we), .vpc_inc(vpc_inc),
        .acc(acc_i),
        .vpc_q_o(vpc_o), .base_q_o(base_q), .fetch_addr_o(fetch_addr)
    );

    bcd_addr_gen #(.ADDR_W(ADDR_W), .BC_W(BC_W)) u_addr (
        .base(base_q), .opcode(pm_data_i), .entry(entry_start)
    );

    bcd_seq #(.ADDR_W(ADDR_W), .BC_W(BC_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .go(go), .fetch_addr(fetch_addr), .entry_start(entry_start),
        .pm_data(pm_data_i),
        .idle_o(seq_idle), .pm_req_o(pm_req_o), .pm_addr_o(pm_addr_o),
        .vpc_inc_o(vpc_inc), .pc_load_o(pc_load_o), .pc_target_o(pc_target_o)
    );

    // R6
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> busy_o);

    // R2
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_req_o |-> busy_o);

    // R11
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_idle && base_load_i) |=> $stable(base_q));
endmodule

// File: tb/bc_dispatch_test.sv
module bc_dispatch_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dispatch_i = 1'b0, vpc_load_i = 1'b0, base_load_i = 1'b0;
    logic [15:0] acc_i = '0;
    logic [15:0] vpc_o, pm_addr_o, pc_target_o;
    logic        pm_req_o, busy_o, pc_load_o;
    logic [7:0]  pm_data_i = '0;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0;
    logic [15:0] exp_vpc = '0, exp_base = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bc_dispatch uut (
        .clk(clk), .rst_n(rst_n), .dispatch_i(dispatch_i), .vpc_load_i(vpc_load_i),
        .base_load_i(base_load_i), .acc_i(acc_i), .vpc_o(vpc_o), .pm_req_o(pm_req_o),
        .pm_addr_o(pm_addr_o), .pm_data_i(pm_data_i), .busy_o(busy_o),
        .pc_load_o(pc_load_o), .pc_target_o(pc_target_o)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] * 8'd13) ^ a[15:8];
    endfunction

    always @(posedge clk) if (pm_req_o) pm_data_i <= mem_byte(pm_addr_o);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Full dispatch; optional same-cycle loads and a poke while busy.
    task automatic run_dispatch(input bit ld_v, input bit ld_b, input logic [15:0] acc_v, input bit poke);
        logic [7:0]  bc;
        logic [15:0] entry, tgt;
        @(negedge clk);
        dispatch_i = 1; vpc_load_i = ld_v; base_load_i = ld_b; acc_i = acc_v;
        if (ld_v) exp_vpc = acc_v;
        if (ld_b) exp_base = acc_v;
        #1;
        chk(busy_o, "R6 busy at dispatch", busy_o, 1);
        chk(pm_req_o && pm_addr_o == exp_vpc, ld_v ? "R9 fetch addr" : "R2 fetch addr", pm_addr_o, exp_vpc);
        bc    = mem_byte(exp_vpc);
        entry = exp_base + 16'(bc) * 16'd2;
        tgt   = {mem_byte(entry + 16'd1), mem_byte(entry)};
        @(negedge clk);
        dispatch_i = 0; vpc_load_i = 0; base_load_i = 0;
        #1;
        chk(pm_req_o && pm_addr_o == entry, ld_b ? "R10 entry low addr" : "R3 entry low addr", pm_addr_o, entry);
        chk(busy_o, "R6 busy in decode", busy_o, 1);
        if (poke) begin
            dispatch_i = 1; vpc_load_i = 1; base_load_i = 1; acc_i = 16'h5A5A;
        end
        @(negedge clk);
        dispatch_i = 0; vpc_load_i = 0; base_load_i = 0;
        #1;
        chk(pm_req_o && pm_addr_o == entry + 16'd1, "R3 entry high addr", pm_addr_o, entry + 16'd1);
        chk(!pc_load_o, "R4 no early redirect", pc_load_o, 0);
        @(negedge clk); #1;
        chk(!pc_load_o && !pm_req_o, "R4 no early redirect", pc_load_o, 0);
        @(negedge clk); #1;
        chk(pc_load_o, "R4 redirect strobe", pc_load_o, 1);
        chk(pc_target_o == tgt, "R4 handler target", pc_target_o, tgt);
        chk(busy_o, "R6 busy at redirect", busy_o, 1);
        exp_vpc = exp_vpc + 16'd1;
        @(negedge clk); #1;
        chk(!busy_o && !pc_load_o, poke ? "R11 no second dispatch" : "R6 busy released", {busy_o, pc_load_o}, 0);
        chk(vpc_o == exp_vpc, poke ? "R11 VPC kept" : "R5 VPC advanced", vpc_o, exp_vpc);
    endtask

    task automatic test_reset();
        #1;
        chk(vpc_o == 0 && !busy_o && !pc_load_o && !pm_req_o, "R1 reset state",
            {vpc_o, busy_o, pc_load_o, pm_req_o}, 0);
        @(negedge clk); rst_n = 1; #1;
        chk(vpc_o == 0 && !busy_o, "R1 after reset release", vpc_o, 0);
        run_dispatch(0, 0, 16'h0, 0); // R1 base cleared: entry indexes from 0
    endtask

    task automatic test_loads();
        @(negedge clk); vpc_load_i = 1; acc_i = 16'h1234; exp_vpc = 16'h1234;
        @(negedge clk); vpc_load_i = 0; #1;
        chk(vpc_o == 16'h1234, "R7 VPC load", vpc_o, 16'h1234);
        @(negedge clk); base_load_i = 1; acc_i = 16'h8000; exp_base = 16'h8000;
        @(negedge clk); base_load_i = 0; #1;
        chk(!busy_o, "R8 base load no busy", busy_o, 0);
        run_dispatch(0, 0, 16'h0, 0); // R8 new base used
        run_dispatch(0, 0, 16'h0, 0); // R5 consecutive
    endtask

    task automatic test_same_cycle();
        run_dispatch(1, 0, 16'h0456, 0); // R9
        run_dispatch(0, 1, 16'h3001, 0); // R10
    endtask

    task automatic test_busy_poke();
        run_dispatch(0, 0, 16'h0, 1);    // R11
        run_dispatch(0, 0, 16'h0, 0);    // R11 base unchanged by poke
    endtask

    task automatic test_wrap();
        @(negedge clk); base_load_i = 1; acc_i = 16'hFFFF; exp_base = 16'hFFFF;
        @(negedge clk); base_load_i = 0;
        run_dispatch(1, 0, 16'hFFFF, 0); // R5 wrap to 0
        chk(vpc_o == 16'h0000, "R5 VPC wrap", vpc_o, 0);
        run_dispatch(0, 0, 16'h0, 0);    // R3 opcode 0 at base FFFF: high byte wraps to 0
    endtask

    initial begin
        test_reset();
        test_loads();
        test_same_cycle();
        test_busy_poke();
        test_wrap();
        finish_run();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
            finish_run();
        end
    end
endmodule